// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block watches the fill levels of an eight-entry transmit FIFO and an eight-entry receive FIFO and turns them into request lines for a DMA controller. Each direction has its own DMA channel. Each channel gets two request lines, and both can be high at the same time. The single-transfer line means at least one element can move. The burst line means at least four elements can move. The transmit side counts free slots, which is the depth minus the fill level. The receive side counts filled entries. Each direction has an enable bit, and when that bit is low both of its request lines stay low.

The block also keeps one completion flag per direction. A done strobe from the DMA controller sets the flag, and a write-one clear strobe clears it. Each flag is gated by its own mask bit to form an interrupt line.

Each direction runs a request state machine with three states:
- `LANE_OFF`: no request.
- `LANE_SINGLE`: single request only.
- `LANE_BURST`: single and burst requests.

On every clock edge the next state depends only on the enable bit and the movable count. The transitions are:
- off, taken when the lane is disabled or nothing can move.
- single, taken when one to three elements can move.
- burst, taken when four or more elements can move.

Each completion flag runs a two-state machine. `FLAG_IDLE` moves to `FLAG_PEND` on the set transition, which is a done strobe. `FLAG_PEND` returns to `FLAG_IDLE` on the clear transition, which is a clear strobe with no done strobe in the same cycle.

Top module: `fifo_dma_req`

## Requirements
- R1: The cycle after a clock edge that sampled `rx_dma_en`=1 and `rx_level`>=1, `rx_req_single` is 1. After an edge that sampled `rx_level`=0, it is 0.
- R2: After an edge that sampled `rx_dma_en`=1 and `rx_level`>=4, `rx_req_burst` is 1. After an edge that sampled `rx_level`<=3, it is 0.
- R3: Transmit free space is 8 minus `tx_level`. After an edge that sampled `tx_dma_en`=1 and free space >=1 (level <=7), `tx_req_single` is 1. After an edge that sampled level 8, it is 0.
- R4: After an edge that sampled `tx_dma_en`=1 and free space >=4 (level <=4), `tx_req_burst` is 1. After an edge that sampled level >=5, it is 0.
- R5: After an edge that sampled a direction's enable bit at 0, both of that direction's request lines are 0, whatever the level.
- R6: The request lines are registered. A change of level or enable does not reach them before the next rising clock edge.
- R7: A level input above 8 is treated as a full FIFO. Transmit then sees no free space, and receive sees eight entries.
- R8: A done strobe (`tx_done`/`rx_done`) sampled at an edge makes the raw flag (`tx_done_raw`/`rx_done_raw`) 1 after that edge, whether or not the mask bit is set.
- R9: A raw flag stays 1 until an edge samples its clear strobe with no done strobe, and it is 0 after that edge. If done and clear are sampled together, the flag ends at 1. A clear strobe on a flag that is already clear leaves it at 0.
- R10: Each interrupt output is its raw flag ANDed with its mask bit, combinationally, so a mask change shows up within the same cycle.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 4 | Transmit FIFO fill level (0 to 8) |
| rx_level | input | 4 | Receive FIFO fill level (0 to 8) |
| tx_dma_en | input | 1 | Enables transmit DMA requests |
| rx_dma_en | input | 1 | Enables receive DMA requests |
| tx_done | input | 1 | Transmit DMA completion strobe |
| rx_done | input | 1 | Receive DMA completion strobe |
| tx_flag_clr | input | 1 | Write-one clear of the transmit completion flag |
| rx_flag_clr | input | 1 | Write-one clear of the receive completion flag |
| tx_int_mask | input | 1 | Transmit completion interrupt mask (1 = enabled) |
| rx_int_mask | input | 1 | Receive completion interrupt mask (1 = enabled) |
| tx_req_single | output | 1 | Transmit single-transfer request |
| tx_req_burst | output | 1 | Transmit burst request |
| rx_req_single | output | 1 | Receive single-transfer request |
| rx_req_burst | output | 1 | Receive burst request |
| tx_done_raw | output | 1 | Transmit completion flag before masking |
| rx_done_raw | output | 1 | Receive completion flag before masking |
| tx_done_irq | output | 1 | Masked transmit completion interrupt |
| rx_done_irq | output | 1 | Masked receive completion interrupt |

## Verification
The bench sweeps every pair of 4-bit levels against every enable combination. This catches:
- an off-by-one threshold, such as a burst at three or five, or a transmit request when full;
- a transmit side that counts entries instead of free slots;
- a level above eight that wraps instead of saturating.

Each sweep step also checks the outputs before the clock edge, so a combinational path that skips the register shows up as an early change. The flag tests raise a done strobe while the mask is off, which catches a design that drops masked events. They also drive done and clear in the same cycle, which catches a design that lets the clear win, and they toggle the mask mid-cycle, which catches an interrupt line that was registered by mistake.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    // Each state bit is also an output bit: bit 0 is the single request, bit 1 the burst request.
    typedef enum logic [1:0] {
        LANE_OFF    = 2'b00,
        LANE_SINGLE = 2'b01,
        LANE_BURST  = 2'b11
    } lane_state_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/fdr_lane.sv
module fdr_lane
    import fdr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    parameter bit IS_TX = 1'b0,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic             dma_en,
    output logic             req_single,
    output logic             req_burst
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

    logic [CNT_W-1:0] avail;
    lane_state_e      state_q;
    lane_state_e      state_d;

    // Movable element count: free slots for transmit, filled entries for receive.
    generate
        if (IS_TX) begin : g_tx_space
            always_comb begin
                if (level >= DEPTH_C) begin
                    avail = '0;
                end else begin
                    avail = DEPTH_C - level;
                end
            end
        end else begin : g_rx_fill
            always_comb begin
                if (level > DEPTH_C) begin
                    avail = DEPTH_C;
                end else begin
                    avail = level;
                end
            end
        end
    endgenerate

    // Next-state selection
    always_comb begin
        if (!dma_en || avail == '0) begin
            state_d = LANE_OFF;
        end else if (avail >= BURST_C) begin
            state_d = LANE_BURST;
        end else begin
            state_d = LANE_SINGLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LANE_OFF: begin
                req_single = 1'b0;
                req_burst  = 1'b0;
            end
            LANE_SINGLE: begin
                req_single = 1'b1;
                req_burst  = 1'b0;
            end
            LANE_BURST: begin
                req_single = 1'b1;
                req_burst  = 1'b1;
            end
            default: begin
                req_single = 1'b0;
                req_burst  = 1'b0;
            end
        endcase
    end

    // Single request follows a non-zero movable count (R1, R3)
    p_single_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && avail != '0) |=> req_single);
    p_single_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (avail == '0) |=> !req_single);

    // Burst request follows the threshold (R2, R4)
    p_burst_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && avail >= BURST_C) |=> req_burst);
    p_burst_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (avail < BURST_C) |=> !req_burst);

    // A disabled lane stays quiet (R5)
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> (!req_single && !req_burst));

endmodule

// File: rtl/fdr_cmpl.sv
module fdr_cmpl
    import fdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic clr,
    input  logic mask,
    output logic raw,
    output logic irq
);

    flag_state_e state_q;
    flag_state_e state_d;

    // Next-state logic: a done strobe takes priority over a clear strobe.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (done)        state_d = FLAG_PEND;
            FLAG_PEND: if (clr && !done) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output logic
    always_comb begin
        raw = (state_q == FLAG_PEND);
        irq = raw & mask;
    end

    p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> raw);
    p_flag_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> !raw);
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr) |=> raw);
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req #(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             tx_done,
    input  logic             rx_done,
    input  logic             tx_flag_clr,
    input  logic             rx_flag_clr,
    input  logic             tx_int_mask,
    input  logic             rx_int_mask,
    output logic             tx_req_single,
    output logic             tx_req_burst,
    output logic             rx_req_single,
    output logic             rx_req_burst,
    output logic             tx_done_raw,
    output logic             rx_done_raw,
    output logic             tx_done_irq,
    output logic             rx_done_irq
);

    fdr_lane #(.DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b1), .CNT_W(CNT_W)) u_tx_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (tx_level),
        .dma_en     (tx_dma_en),
        .req_single (tx_req_single),
        .req_burst  (tx_req_burst)
    );

    fdr_lane #(.DEPTH(DEPTH), .BURST(BURST), .IS_TX(1'b0), .CNT_W(CNT_W)) u_rx_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (rx_level),
        .dma_en     (rx_dma_en),
        .req_single (rx_req_single),
        .req_burst  (rx_req_burst)
    );

    fdr_cmpl u_tx_cmpl (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (tx_done),
        .clr   (tx_flag_clr),
        .mask  (tx_int_mask),
        .raw   (tx_done_raw),
        .irq   (tx_done_irq)
    );

    fdr_cmpl u_rx_cmpl (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (rx_done),
        .clr   (rx_flag_clr),
        .mask  (rx_int_mask),
        .raw   (rx_done_raw),
        .irq   (rx_done_irq)
    );

    // Reset state of every output (R11)
    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r11: assert ({tx_req_single, tx_req_burst, rx_req_single, rx_req_burst,
                                        tx_done_raw, rx_done_raw, tx_done_irq, rx_done_irq} == 8'h00);
        end
    end

endmodule

// File: tb/fifo_dma_req_tb.sv
module fifo_dma_req_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_level = '0;
    logic [3:0] rx_level = '0;
    logic       tx_dma_en = 1'b0;
    logic       rx_dma_en = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic       tx_flag_clr = 1'b0;
    logic       rx_flag_clr = 1'b0;
    logic       tx_int_mask = 1'b0;
    logic       rx_int_mask = 1'b0;
    logic       tx_req_single, tx_req_burst, rx_req_single, rx_req_burst;
    logic       tx_done_raw, rx_done_raw, tx_done_irq, rx_done_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    fifo_dma_req u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_done(tx_done), .rx_done(rx_done),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .tx_int_mask(tx_int_mask), .rx_int_mask(rx_int_mask),
        .tx_req_single(tx_req_single), .tx_req_burst(tx_req_burst),
        .rx_req_single(rx_req_single), .rx_req_burst(rx_req_burst),
        .tx_done_raw(tx_done_raw), .rx_done_raw(rx_done_raw),
        .tx_done_irq(tx_done_irq), .rx_done_irq(rx_done_irq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Expected request pair from the requirements: free space for tx, fill for rx
    function automatic logic [1:0] exp_req(input bit is_tx, input int lvl, input bit en);
        int av;
        if (is_tx) av = (lvl >= 8) ? 0 : 8 - lvl;
        else       av = (lvl > 8) ? 8 : lvl;
        return {en && av >= 4, en && av >= 1};  // {burst, single}
    endfunction

    function automatic string req_tag(input bit is_tx, input int lvl, input bit en, input bit burst);
        if (!en)     return "R5";
        if (lvl > 8) return "R7";
        if (is_tx)   return burst ? "R4" : "R3";
        return burst ? "R2" : "R1";
    endfunction

    task automatic set_flag_in(input bit dir, input bit d, input bit c);
        if (dir) begin rx_done = d; rx_flag_clr = c; end
        else     begin tx_done = d; tx_flag_clr = c; end
    endtask

    task automatic set_mask(input bit dir, input bit m);
        if (dir) rx_int_mask = m; else tx_int_mask = m;
    endtask

    function automatic logic get_raw(input bit dir);
        return dir ? rx_done_raw : tx_done_raw;
    endfunction

    function automatic logic get_irq(input bit dir);
        return dir ? rx_done_irq : tx_done_irq;
    endfunction

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_tx;
        logic [1:0] prev_rx;
        logic [1:0] et;
        logic [1:0] er;

        // R11: reset state
        tx_level = 4'd2; rx_level = 4'd6; tx_dma_en = 1'b1; rx_dma_en = 1'b1;
        tx_done = 1'b1; rx_done = 1'b1; tx_int_mask = 1'b1; rx_int_mask = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset outputs", |{tx_req_single, tx_req_burst, rx_req_single, rx_req_burst,
              tx_done_raw, rx_done_raw, tx_done_irq, rx_done_irq}, 1'b0);
        @(negedge clk);
        tx_dma_en = 1'b0; rx_dma_en = 1'b0; tx_done = 1'b0; rx_done = 1'b0;
        tx_int_mask = 1'b0; rx_int_mask = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        prev_tx = 2'b00; prev_rx = 2'b00;

        // Sweep all levels and enables (R1-R7)
        for (int tl = 0; tl < 16; tl++) begin
            for (int rl = 0; rl < 16; rl++) begin
                for (int e = 0; e < 4; e++) begin
                    @(negedge clk);
                    tx_level = 4'(tl); rx_level = 4'(rl);
                    tx_dma_en = e[0]; rx_dma_en = e[1];
                    et = exp_req(1'b1, tl, e[0]);
                    er = exp_req(1'b0, rl, e[1]);
                    #1;
                    // R6: nothing moves before the clock edge
                    check("R6", "tx single held", tx_req_single, prev_tx[0]);
                    check("R6", "tx burst held",  tx_req_burst,  prev_tx[1]);
                    check("R6", "rx single held", rx_req_single, prev_rx[0]);
                    check("R6", "rx burst held",  rx_req_burst,  prev_rx[1]);
                    @(posedge clk); #1;
                    check(req_tag(1'b1, tl, e[0], 1'b0), "tx single", tx_req_single, et[0]);
                    check(req_tag(1'b1, tl, e[0], 1'b1), "tx burst",  tx_req_burst,  et[1]);
                    check(req_tag(1'b0, rl, e[1], 1'b0), "rx single", rx_req_single, er[0]);
                    check(req_tag(1'b0, rl, e[1], 1'b1), "rx burst",  rx_req_burst,  er[1]);
                    prev_tx = et; prev_rx = er;
                end
            end
        end

        @(negedge clk);
        tx_dma_en = 1'b0; rx_dma_en = 1'b0;

        // Completion flags (R8, R9, R10)
        for (int dir = 0; dir < 2; dir++) begin
            for (int m = 0; m < 2; m++) begin
                @(negedge clk);
                set_mask(dir[0], m[0]);
                set_flag_in(dir[0], 1'b1, 1'b0);
                #1;
                check("R8", "raw before edge", get_raw(dir[0]), 1'b0);
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b0);
                #1;
                check("R8", "raw set", get_raw(dir[0]), 1'b1);
                check("R10", "irq follows mask", get_irq(dir[0]), m[0]);
                repeat (3) @(posedge clk);
                #1;
                check("R9", "raw held", get_raw(dir[0]), 1'b1);
                // R10: combinational mask change
                @(negedge clk);
                set_mask(dir[0], !m[0]);
                #1;
                check("R10", "irq on mask flip", get_irq(dir[0]), !m[0]);
                set_mask(dir[0], m[0]);
                #1;
                check("R10", "irq on mask restore", get_irq(dir[0]), m[0]);
                // R9: done and clear together keeps the flag
                @(negedge clk);
                set_flag_in(dir[0], 1'b1, 1'b1);
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b0);
                #1;
                check("R9", "done wins over clear", get_raw(dir[0]), 1'b1);
                // R9: clear alone
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b1);
                #1;
                check("R9", "raw before clear edge", get_raw(dir[0]), 1'b1);
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b0);
                #1;
                check("R9", "raw cleared", get_raw(dir[0]), 1'b0);
                check("R10", "irq cleared", get_irq(dir[0]), 1'b0);
                check("R8", "other flag untouched", get_raw(!dir[0]), 1'b0);
                // R9: clear on an idle flag
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b1);
                @(negedge clk);
                set_flag_in(dir[0], 1'b0, 1'b0);
                #1;
                check("R9", "idle clear", get_raw(dir[0]), 1'b0);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule